// File: doc/BRIEF.md
# Token-Rotating Ring Crossbar Scheduler

This block schedules packet transfers among four ports placed as four nodes on a bidirectional ring. Each node drives one link toward its clockwise neighbour and one toward its counter-clockwise neighbour. A port offers a header naming a destination output. The header is held until the port wins a round. Each round, the scheduler picks a set of transfers in which no output and no ring link is used twice. It then routes the body beats of the granted inputs to their outputs, signals completion, and moves the token one node on.

A token marks the node with top priority. The token holder is served first. The other ports follow in clockwise order from the token. Because the token moves every round, each port holds top priority once every four rounds. Every transfer takes the shorter way around the ring. A transfer to the node directly across the ring always goes clockwise.

Top module: `ring_xbar_sched`

## Requirements
- R1: After reset the token is at node 0, `grant`, `out_valid` and `round_done` are 0, and `hdr_ready` is 4'b1111.
- R2: Input i offers a header through `hdr_valid[i]`, with the destination in `hdr_dest[2i+1:2i]`. The header is taken at a clock edge where `hdr_valid[i]` and `hdr_ready[i]` are both high. `hdr_ready[i]` stays low while a header is held. An input with no held header makes no request.
- R3: If the token holder holds a header when the allocation is made, it is always granted.
- R4: The other inputs are considered in the order token+1, token+2, token+3 (mod 4). Each is granted only if its output and every link on its path are still unused. No output is driven by two inputs.
- R5: The path has d = (dest − src) mod 4. For d = 1, the path is the clockwise link leaving src. For d = 2, it is the clockwise links leaving src and src+1. For d = 3, it is the counter-clockwise link leaving src. For d = 0, it uses no link. The two directions of a link are separate resources.
- R6: A round lasts BEATS+3 cycles: one gather cycle, one allocation cycle, BEATS transfer cycles and one confirm cycle. `grant` and `out_valid` are high only in the transfer cycles and hold steady through them. `round_done` is high only in the confirm cycle.
- R7: During transfer cycles, `out_data` lane o (bits [8o+7:8o] at DW=8) equals the `in_data` lane of the input granted to output o. Lanes with no grant are 0.
- R8: A granted header is released at the end of the confirm cycle. A denied header is kept and competes again in the next round.
- R9: The token advances by one (mod 4) at the end of every round, including rounds with no grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hdr_valid | input | 4 | Header offer, one bit per input |
| hdr_dest | input | 8 | Destination output, 2 bits per input |
| hdr_ready | output | 4 | Input can take a new header |
| in_data | input | 4*DW | Body lanes, DW bits per input |
| grant | output | 4 | Input i is transferring this cycle |
| out_valid | output | 4 | Output o is receiving this cycle |
| out_data | output | 4*DW | Routed body lanes, DW bits per output |
| token | output | 2 | Node holding top priority |
| round_done | output | 1 | Confirm cycle of the round |

## Verification
Two things happen at the edge that closes the confirm cycle: the token advances, and the granted headers are released. Denied headers stay held at that same edge, so the next allocation uses a new token together with leftover requests. The bench sweeps every header pattern against every token position while carrying those leftover headers from round to round. A model of the held headers predicts the grants, and each round it checks `hdr_ready`, the grant set, the routed lanes and the new token.

// File: rtl/ring_xbar_pkg.sv
package ring_xbar_pkg;
  localparam int NODES = 4;
  localparam int IDX_W = 2;
  localparam int LINKS = 2 * NODES;

  typedef logic [IDX_W-1:0] node_t;

  typedef enum logic [1:0] {
    PH_GATHER,
    PH_ALLOC,
    PH_XFER,
    PH_CONFIRM
  } phase_t;

  // clockwise hop count from src to dst
  function automatic node_t cw_hops(node_t src, node_t dst);
    return node_t'(dst - src);
  endfunction

  // links used: [NODES-1:0] clockwise leaving node n,
  // [LINKS-1:NODES] counter-clockwise arriving at node n from n+1
  function automatic logic [LINKS-1:0] path_links(node_t src, node_t dst);
    logic [LINKS-1:0] m;
    m = '0;
    case (cw_hops(src, dst))
      2'd1: m[src] = 1'b1;
      2'd2: begin
        m[src] = 1'b1;
        m[node_t'(src + 2'd1)] = 1'b1;
      end
      2'd3: m[NODES + int'(node_t'(src - 2'd1))] = 1'b1;
      default: m = '0;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/rxb_hdr_hold.sv
module rxb_hdr_hold
  import ring_xbar_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NODES-1:0]       hdr_valid,
  input  logic [NODES*IDX_W-1:0] hdr_dest,
  input  logic [NODES-1:0]       release_mask,
  output logic [NODES-1:0]       pend,
  output logic [NODES*IDX_W-1:0] dest_q,
  output logic [NODES-1:0]       hdr_ready
);
  for (genvar n = 0; n < NODES; n++) begin : g_port
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend[n] <= 1'b0;
        dest_q[n*IDX_W +: IDX_W] <= '0;
      end else if (release_mask[n]) begin
        pend[n] <= 1'b0;
      end else if (hdr_valid[n] && !pend[n]) begin
        pend[n] <= 1'b1;
        dest_q[n*IDX_W +: IDX_W] <= hdr_dest[n*IDX_W +: IDX_W];
      end
    end
    assign hdr_ready[n] = ~pend[n];
  end
endmodule

// File: rtl/rxb_alloc.sv
module rxb_alloc
  import ring_xbar_pkg::*;
(
  input  logic [NODES-1:0]       pend,
  input  logic [NODES*IDX_W-1:0] dest,
  input  node_t                  token,
  output logic [NODES-1:0]       gnt,
  output logic [NODES-1:0]       ovld,
  output logic [NODES*IDX_W-1:0] osrc
);
  node_t            cand;
  node_t            tgt;
  logic [LINKS-1:0] need;
  logic [LINKS-1:0] link_busy;

  always_comb begin
    gnt       = '0;
    ovld      = '0;
    osrc      = '0;
    link_busy = '0;
    cand      = token;
    tgt       = '0;
    need      = '0;
    for (int k = 0; k < NODES; k++) begin
      cand = node_t'(token + node_t'(k));
      tgt  = dest[cand*IDX_W +: IDX_W];
      need = path_links(cand, tgt);
      if (pend[cand] && !ovld[tgt] && ((need & link_busy) == '0)) begin
        gnt[cand]                 = 1'b1;
        ovld[tgt]                 = 1'b1;
        osrc[tgt*IDX_W +: IDX_W]  = cand;
        link_busy                 = link_busy | need;
      end
    end
  end
endmodule

// File: rtl/rxb_round_ctl.sv
module rxb_round_ctl
  import ring_xbar_pkg::*;
#(
  parameter int BEATS = 4
) (
  input  logic   clk,
  input  logic   rst_n,
  output phase_t phase,
  output node_t  token
);
  localparam int BW = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam logic [BW-1:0] LAST = BW'(BEATS - 1);

  logic [BW-1:0] beat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_GATHER;
      beat  <= '0;
      token <= '0;
    end else begin
      case (phase)
        PH_GATHER: phase <= PH_ALLOC;
        PH_ALLOC: begin
          phase <= PH_XFER;
          beat  <= '0;
        end
        PH_XFER: begin
          if (beat == LAST) phase <= PH_CONFIRM;
          else beat <= beat + 1'b1;
        end
        default: begin
          token <= token + 2'd1;
          phase <= PH_GATHER;
        end
      endcase
    end
  end
endmodule

// File: rtl/ring_xbar_sched.sv
module ring_xbar_sched
  import ring_xbar_pkg::*;
#(
  parameter int DW    = 8,
  parameter int BEATS = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NODES-1:0]       hdr_valid,
  input  logic [NODES*IDX_W-1:0] hdr_dest,
  output logic [NODES-1:0]       hdr_ready,
  input  logic [NODES*DW-1:0]    in_data,
  output logic [NODES-1:0]       grant,
  output logic [NODES-1:0]       out_valid,
  output logic [NODES*DW-1:0]    out_data,
  output logic [IDX_W-1:0]       token,
  output logic                   round_done
);
  phase_t                 phase;
  logic                   alloc_evt;
  logic                   xfer_evt;
  logic [NODES-1:0]       pend;
  logic [NODES*IDX_W-1:0] dest_q;
  logic [NODES-1:0]       gnt_nxt;
  logic [NODES-1:0]       ovld_nxt;
  logic [NODES*IDX_W-1:0] osrc_nxt;
  logic [NODES-1:0]       gnt_q;
  logic [NODES-1:0]       ovld_q;
  logic [NODES*IDX_W-1:0] osrc_q;
  logic [NODES-1:0]       release_mask;

  rxb_round_ctl #(.BEATS(BEATS)) u_ctl (
    .clk(clk), .rst_n(rst_n), .phase(phase), .token(token)
  );

  assign alloc_evt    = (phase == PH_ALLOC);
  assign xfer_evt     = (phase == PH_XFER);
  assign round_done   = (phase == PH_CONFIRM);
  assign release_mask = gnt_q & {NODES{round_done}};

  rxb_hdr_hold u_hold (
    .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_dest(hdr_dest),
    .release_mask(release_mask), .pend(pend), .dest_q(dest_q),
    .hdr_ready(hdr_ready)
  );

  rxb_alloc u_alloc (
    .pend(pend), .dest(dest_q), .token(token),
    .gnt(gnt_nxt), .ovld(ovld_nxt), .osrc(osrc_nxt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gnt_q  <= '0;
      ovld_q <= '0;
      osrc_q <= '0;
    end else if (alloc_evt) begin
      gnt_q  <= gnt_nxt;
      ovld_q <= ovld_nxt;
      osrc_q <= osrc_nxt;
    end else if (round_done) begin
      gnt_q  <= '0;
      ovld_q <= '0;
    end
  end

  assign grant     = gnt_q & {NODES{xfer_evt}};
  assign out_valid = ovld_q & {NODES{xfer_evt}};

  for (genvar o = 0; o < NODES; o++) begin : g_lane
    node_t sel;
    assign sel = osrc_q[o*IDX_W +: IDX_W];
    assign out_data[o*DW +: DW] = out_valid[o] ? in_data[sel*DW +: DW] : '0;
  end
endmodule

// File: rtl/ring_xbar_sched_chk.sv
module ring_xbar_sched_chk
  import ring_xbar_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             alloc_evt,
  input logic             xfer_evt,
  input logic [NODES-1:0] pend,
  input logic [IDX_W-1:0] token,
  input logic [NODES-1:0] grant,
  input logic [NODES-1:0] out_valid,
  input logic [NODES-1:0] hdr_ready,
  input logic             round_done
);
  assert_holder_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_evt && pend[token]) |=> grant[$past(token)]);

  assert_one_per_output_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(out_valid) == $countones(grant));

  assert_grant_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_evt && $past(xfer_evt)) |-> $stable(grant));

  assert_quiet_outside_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_evt |-> (grant == '0 && out_valid == '0));

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    round_done |=> !round_done);

  assert_held_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & hdr_ready) == '0);

  assert_token_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    round_done |=> token == $past(token) + 2'd1);
endmodule

bind ring_xbar_sched ring_xbar_sched_chk u_chk (
  .clk(clk), .rst_n(rst_n), .alloc_evt(alloc_evt), .xfer_evt(xfer_evt),
  .pend(pend), .token(token), .grant(grant), .out_valid(out_valid),
  .hdr_ready(hdr_ready), .round_done(round_done)
);

// File: tb/ring_xbar_sched_bench.sv
module ring_xbar_sched_bench;
  localparam int DW = 8;
  localparam int BEATS = 4;
  localparam int ROUNDS = 2500;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [3:0]      hdr_valid = '0;
  logic [7:0]      hdr_dest = '0;
  logic [3:0]      hdr_ready;
  logic [4*DW-1:0] in_data = '0;
  logic [3:0]      grant;
  logic [3:0]      out_valid;
  logic [4*DW-1:0] out_data;
  logic [1:0]      token;
  logic            round_done;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 1'b0;

  logic [3:0] m_pend = '0;
  int         m_dest[4];
  int         m_tok = 0;
  logic [3:0] m_gnt;
  logic [3:0] m_ovld;
  int         m_src[4];

  always #5 clk = ~clk;

  ring_xbar_sched #(.DW(DW), .BEATS(BEATS)) u_ring_xbar_sched (
    .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_dest(hdr_dest),
    .hdr_ready(hdr_ready), .in_data(in_data), .grant(grant),
    .out_valid(out_valid), .out_data(out_data), .token(token),
    .round_done(round_done)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // model: walk hops node by node, marking each directed hop as used
  task automatic model_alloc();
    bit cw_used[4];
    bit ccw_used[4];
    bit out_used[4];
    for (int n = 0; n < 4; n++) begin
      cw_used[n] = 0; ccw_used[n] = 0; out_used[n] = 0; m_src[n] = 0;
    end
    m_gnt = '0; m_ovld = '0;
    for (int k = 0; k < 4; k++) begin
      int s, d, steps, dir, cur;
      bit free;
      s = (m_tok + k) % 4;
      if (!m_pend[s]) continue;
      d = (m_dest[s] - s + 4) % 4;
      dir = (d <= 2) ? 1 : -1;
      steps = (d <= 2) ? d : 4 - d;
      free = !out_used[m_dest[s]];
      cur = s;
      for (int h = 0; h < steps; h++) begin
        if (dir == 1 && cw_used[cur]) free = 0;
        if (dir == -1 && ccw_used[cur]) free = 0;
        cur = (cur + dir + 4) % 4;
      end
      if (free) begin
        cur = s;
        for (int h = 0; h < steps; h++) begin
          if (dir == 1) cw_used[cur] = 1; else ccw_used[cur] = 1;
          cur = (cur + dir + 4) % 4;
        end
        out_used[m_dest[s]] = 1;
        m_gnt[s] = 1'b1;
        m_ovld[m_dest[s]] = 1'b1;
        m_src[m_dest[s]] = s;
      end
    end
  endtask

  function automatic logic [DW-1:0] lane_val(int i, int b, int r);
    return {i[1:0], 3'(b), 3'(r)};
  endfunction

  initial begin
    while (!finished) begin
      @(posedge clk);
      cycles++;
      if (cycles > 200000) begin
        errors++;
        $display("FAIL watchdog: actual 0x%0h expected 0x%0h", cycles, 200000);
        finish_run();
      end
    end
  end

  initial begin
    int pow5[4];
    pow5[0] = 1; pow5[1] = 5; pow5[2] = 25; pow5[3] = 125;
    for (int n = 0; n < 4; n++) m_dest[n] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(token == 2'd0, "R1 token", 32'(token), 0);
    chk(grant == 4'd0 && out_valid == 4'd0, "R1 grant/out_valid",
        {grant, out_valid}, 0);
    chk(hdr_ready == 4'hf && !round_done, "R1 hdr_ready/round_done",
        {hdr_ready, 3'b0, round_done}, 32'hf0);

    for (int r = 0; r < ROUNDS; r++) begin
      int p;
      logic [3:0] pend_before;
      p = r / 4;
      hdr_valid = '0;
      for (int i = 0; i < 4; i++) begin
        int dg;
        dg = (p / pow5[i]) % 5;
        if (!m_pend[i] && dg < 4) begin
          hdr_valid[i] = 1'b1;
          hdr_dest[i*2 +: 2] = 2'(dg);
          m_pend[i] = 1'b1;
          m_dest[i] = dg;
        end
      end
      @(posedge clk);
      @(negedge clk);
      hdr_valid = '0;
      chk(hdr_ready == ~m_pend, "R2 hdr_ready", 32'(hdr_ready), 32'(~m_pend));
      pend_before = m_pend;
      model_alloc();
      for (int b = 0; b < BEATS; b++) begin
        logic [4*DW-1:0] exp_out;
        @(posedge clk);
        @(negedge clk);
        for (int i = 0; i < 4; i++) in_data[i*DW +: DW] = lane_val(i, b, r);
        #1;
        chk(grant == m_gnt, "R4 grant set", 32'(grant), 32'(m_gnt));
        chk(grant[m_tok] == pend_before[m_tok], "R3 token holder",
            32'(grant[m_tok]), 32'(pend_before[m_tok]));
        chk(out_valid == m_ovld, "R5 path outputs", 32'(out_valid), 32'(m_ovld));
        exp_out = '0;
        for (int o = 0; o < 4; o++)
          if (m_ovld[o]) exp_out[o*DW +: DW] = lane_val(m_src[o], b, r);
        chk(out_data == exp_out, "R7 routed data", out_data, exp_out);
      end
      @(posedge clk);
      @(negedge clk);
      chk(round_done && grant == 4'd0 && out_valid == 4'd0, "R6 confirm cycle",
          {round_done, grant, out_valid}, 32'h100);
      m_pend = m_pend & ~m_gnt;
      m_tok = (m_tok + 1) % 4;
      @(posedge clk);
      @(negedge clk);
      chk(token == 2'(m_tok), "R9 token step", 32'(token), 32'(m_tok));
      chk(hdr_ready == ~m_pend && !round_done, "R8 held headers",
          {round_done, hdr_ready}, 32'(~m_pend));
    end
    finish_run();
  end
endmodule